// File: doc/BRIEF.md
# Priority trace message queue

This block merges trace messages from four producers into one first-in first-out queue: watchpoint hits, ownership changes, branch trace and data trace. It drains them, in the order they were admitted, to an output port with a valid/ready handshake that feeds the trace pin serializer. At most one message is admitted per cycle, and a fixed priority decides which one. A non-data source that loses arbitration keeps its request raised and tries again. A data-trace message that collides with any other source is lost at once.

An offer that meets a full queue starts a discard phase. During that phase every offer is consumed and dropped until the queue has drained completely. The block then writes one error message whose code lists the source types that were turned away. Every lost data-trace message raises a one-cycle pulse, so that a resynchronization controller can force a sync message on the next data access.

Top module: `trace_msg_queue`

## Requirements
- R1: Messages leave through the output in admission order. `out_valid_o` is high exactly when the queue holds at least one entry. An entry is removed on a cycle with `out_valid_o` and `out_ready_i` both high. The queue holds DEPTH entries (default 16).
- R2: When the block is not in discard and the queue is not full, it admits at most one message per cycle. Priority is watchpoint (lane 0), then ownership (lane 1), then branch (lane 2), then data trace (lane 3). `src_accept_o` is high for the admitted lane only. A non-data lane that loses is not accepted and is not queued.
- R3: A data-trace offer (lane 3) made in the same cycle as an offer on any of lanes 0 to 2 is lost. `src_accept_o[3]` and `dtm_lost_o` go high in that cycle, and nothing from lane 3 is queued.
- R4: The message type of a queued entry is taken from its source: 1 for watchpoint, 2 for ownership, 3 for branch, 4 for data trace, and 15 for an error message. The payload of a source message is stored and output unchanged.
- R5: An offer made while the queue holds DEPTH entries puts the block into discard. From then on every offer on every lane is accepted and dropped, and none is queued, until the queue has become empty.
- R6: In the first cycle in which the block is in discard and the queue is empty, the block queues one error message. Its type is 15. Payload bits [3:0] hold one bit per lane (bit 0 watchpoint, bit 1 ownership, bit 2 branch, bit 3 data trace), set if that lane was dropped at any point of the discard phase, including the insertion cycle. All higher payload bits are zero. Normal admission resumes in the next cycle.
- R7: A data-trace offer dropped because of a full queue or discard raises `dtm_lost_o` in that cycle.
- R8: After reset the queue is empty, `out_valid_o` is low and the block is not in discard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | 4 | Offer per lane: 0 watchpoint, 1 ownership, 2 branch, 3 data trace |
| src_payload_i | input | 4x64 | Payload per lane |
| src_accept_o | output | 4 | Offer consumed this cycle (queued or dropped) |
| dtm_lost_o | output | 1 | Data-trace offer lost this cycle |
| out_valid_o | output | 1 | Head entry present |
| out_ready_i | input | 1 | Consumer takes the head entry |
| out_type_o | output | 4 | Message type of the head entry |
| out_payload_o | output | 64 | Payload of the head entry |

## Verification
The assertions take for granted that the inputs change only away from the rising clock edge, and that a lane may withdraw its offer after it has been accepted. They also assume that the data-trace lane makes single-cycle offers that are not retried. The bench drives every offer at the falling edge and samples the accept and lost outputs shortly after that edge. It then holds the offer through exactly one rising edge. It fills the queue only with `out_ready_i` low, so that the overrun point falls on a known entry count, and it drains with no offers raised except where the discard phase is under test.

// File: rtl/tq_pkg.sv
package tq_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned TYPE_W  = 4;
  localparam int unsigned PAY_W   = 64;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);
  localparam logic [TYPE_W-1:0] TYPE_ERR = 4'hF;

  typedef struct packed {
    logic [TYPE_W-1:0] mtype;
    logic [PAY_W-1:0]  payload;
  } tq_entry_t;

  function automatic logic [TYPE_W-1:0] lane_type(input logic [IDX_W-1:0] idx);
    return TYPE_W'(idx) + TYPE_W'(1);
  endfunction
endpackage

// File: rtl/tq_arbiter.sv
module tq_arbiter
  import tq_pkg::*;
(
  input  logic [NUM_SRC-1:0] valid_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic               win_valid_o,
  output logic               dtm_collide_o
);
  // lane 0 highest priority
  always_comb begin
    grant_o     = '0;
    win_idx_o   = '0;
    win_valid_o = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (valid_i[i]) begin
        win_idx_o   = IDX_W'(i);
        win_valid_o = 1'b1;
      end
    end
    if (win_valid_o) grant_o[win_idx_o] = 1'b1;
  end

  assign dtm_collide_o = valid_i[NUM_SRC-1] & (|valid_i[NUM_SRC-2:0]);
endmodule

// File: rtl/tq_fifo.sv
module tq_fifo
  import tq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  tq_entry_t wdata_i,
  input  logic      rd_i,
  output tq_entry_t rdata_o,
  output logic      full_o,
  output logic      empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  tq_entry_t        mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_i) rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (wr_i && !rd_i)      count_q <= count_q + CNT_W'(1);
      else if (rd_i && !wr_i) count_q <= count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);

  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (count_q != CNT_W'(DEPTH)));
  // R1
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> (count_q != '0));
endmodule

// File: rtl/tq_overrun.sv
module tq_overrun
  import tq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] offer_i,
  input  logic               full_i,
  input  logic               empty_i,
  output logic               blocking_o,
  output logic               ins_err_o,
  output logic [NUM_SRC-1:0] err_mask_o
);
  logic               discard_q;
  logic [NUM_SRC-1:0] mask_q;

  assign blocking_o = discard_q | full_i;
  assign ins_err_o  = discard_q & empty_i;
  assign err_mask_o = mask_q | offer_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      discard_q <= 1'b0;
      mask_q    <= '0;
    end else if (ins_err_o) begin
      discard_q <= 1'b0;
      mask_q    <= '0;
    end else if (discard_q) begin
      mask_q    <= mask_q | offer_i;
    end else if (full_i && |offer_i) begin
      discard_q <= 1'b1;
      mask_q    <= offer_i;
    end
  end

  // R5
  discard_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (discard_q && !empty_i) |=> discard_q);
endmodule

// File: rtl/trace_msg_queue.sv
module trace_msg_queue
  import tq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC-1:0]            src_valid_i,
  input  logic [NUM_SRC-1:0][PAY_W-1:0] src_payload_i,
  output logic [NUM_SRC-1:0]            src_accept_o,
  output logic                          dtm_lost_o,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [TYPE_W-1:0]             out_type_o,
  output logic [PAY_W-1:0]              out_payload_o
);
  localparam int unsigned DTM = NUM_SRC - 1;

  logic [NUM_SRC-1:0] grant, err_mask;
  logic [IDX_W-1:0]   win_idx;
  logic               win_valid, dtm_collide;
  logic               blocking, ins_err;
  logic               fifo_wr, fifo_rd, fifo_full, fifo_empty;
  tq_entry_t          wdata, rdata;

  tq_arbiter u_arb (
    .valid_i       (src_valid_i),
    .grant_o       (grant),
    .win_idx_o     (win_idx),
    .win_valid_o   (win_valid),
    .dtm_collide_o (dtm_collide)
  );

  tq_overrun u_ovr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .offer_i    (src_valid_i),
    .full_i     (fifo_full),
    .empty_i    (fifo_empty),
    .blocking_o (blocking),
    .ins_err_o  (ins_err),
    .err_mask_o (err_mask)
  );

  tq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (fifo_wr),
    .wdata_i (wdata),
    .rd_i    (fifo_rd),
    .rdata_o (rdata),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  always_comb begin
    if (ins_err) begin
      wdata.mtype   = TYPE_ERR;
      wdata.payload = PAY_W'(err_mask);
    end else begin
      wdata.mtype   = lane_type(win_idx);
      wdata.payload = src_payload_i[win_idx];
    end
  end

  assign fifo_wr      = ins_err | (win_valid & ~blocking);
  assign fifo_rd      = out_valid_o & out_ready_i;
  assign src_accept_o = blocking ? src_valid_i
                                 : (grant | ({NUM_SRC{dtm_collide}} & (NUM_SRC'(1) << DTM)));
  assign dtm_lost_o   = src_valid_i[DTM] & (blocking | dtm_collide);

  assign out_valid_o   = ~fifo_empty;
  assign out_type_o    = rdata.mtype;
  assign out_payload_o = rdata.payload;

  // R2
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blocking |-> $onehot0(src_accept_o[DTM-1:0]));
  // R3
  dtm_collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_valid_i[DTM] && |src_valid_i[DTM-1:0]) |-> (dtm_lost_o && src_accept_o[DTM]));
  // R5
  discard_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocking && !fifo_empty) |-> !fifo_wr);
  // R6
  err_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_err |=> out_valid_o);
endmodule

// File: tb/sim_trace_msg_queue.sv
`timescale 1ns/1ps
module sim_trace_msg_queue;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       src_valid = '0;
  logic [3:0][63:0] src_payload = '0;
  logic [3:0]       src_accept;
  logic             dtm_lost;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [3:0]       out_type;
  logic [63:0]      out_payload;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  trace_msg_queue #(.DEPTH(16)) u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .src_valid_i   (src_valid),
    .src_payload_i (src_payload),
    .src_accept_o  (src_accept),
    .dtm_lost_o    (dtm_lost),
    .out_valid_o   (out_valid),
    .out_ready_i   (out_ready),
    .out_type_o    (out_type),
    .out_payload_o (out_payload)
  );

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] lane_pay(input logic [63:0] p, input int k);
    return p | (64'(k) << 56);
  endfunction

  // one offer cycle: drive at negedge, sample accept/lost, hold through posedge
  task automatic offer(input logic [3:0] v, input logic [63:0] p,
                       input logic [3:0] exp_acc, input logic exp_lost, input string tag);
    @(negedge clk);
    src_valid = v;
    for (int k = 0; k < 4; k++) src_payload[k] = lane_pay(p, k);
    #1;
    check(128'(src_accept), 128'(exp_acc), {tag, " accept"});
    check(128'(dtm_lost), 128'(exp_lost), {tag, " lost"});
    @(posedge clk);
    #1 src_valid = '0;
  endtask

  task automatic pop_expect(input logic [3:0] t, input logic [63:0] p, input string tag);
    @(negedge clk);
    for (int w = 0; w < 4 && !out_valid; w++) @(negedge clk);
    out_ready = 1'b1;
    #1;
    check(128'({out_valid, out_type, out_payload}), 128'({1'b1, t, p}), tag);
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic expect_empty(input string tag);
    @(negedge clk);
    #1 check(128'(out_valid), 128'(0), tag);
  endtask

  task automatic t_reset;
    #1;
    check(128'(out_valid), 128'(0), "R8 out_valid in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(128'(out_valid), 128'(0), "R8 out_valid after reset");
    check(128'(src_accept), 128'(0), "R8 accept idle");
  endtask

  task automatic t_singles;
    offer(4'b0100, 64'h1000, 4'b0100, 1'b0, "R4 branch alone");
    offer(4'b1000, 64'h2000, 4'b1000, 1'b0, "R4 data alone");
    offer(4'b0001, 64'h3000, 4'b0001, 1'b0, "R4 watch alone");
    offer(4'b0010, 64'h4000, 4'b0010, 1'b0, "R4 owner alone");
    pop_expect(4'h3, lane_pay(64'h1000, 2), "R1 R4 pop branch");
    pop_expect(4'h4, lane_pay(64'h2000, 3), "R1 R4 pop data");
    pop_expect(4'h1, lane_pay(64'h3000, 0), "R1 R4 pop watch");
    pop_expect(4'h2, lane_pay(64'h4000, 1), "R1 R4 pop owner");
    expect_empty("R1 empty after drain");
  endtask

  task automatic t_priority;
    offer(4'b1111, 64'h5000, 4'b1001, 1'b1, "R2 R3 all four");
    offer(4'b0110, 64'h5100, 4'b0010, 1'b0, "R2 owner beats branch");
    offer(4'b1100, 64'h5200, 4'b1100, 1'b1, "R3 data vs branch");
    pop_expect(4'h1, lane_pay(64'h5000, 0), "R2 pop watch first");
    pop_expect(4'h2, lane_pay(64'h5100, 1), "R2 pop owner");
    pop_expect(4'h3, lane_pay(64'h5200, 2), "R3 pop branch, data dropped");
    expect_empty("R3 no data entry");
  endtask

  task automatic t_overrun;
    for (int i = 0; i < 16; i++)
      offer(4'b0100, 64'h100 + 64'(i), 4'b0100, 1'b0, "R1 fill");
    offer(4'b0010, 64'h9000, 4'b0010, 1'b0, "R5 owner hits full");
    offer(4'b1000, 64'h9100, 4'b1000, 1'b1, "R7 data in discard");
    offer(4'b0001, 64'h9200, 4'b0001, 1'b0, "R5 watch in discard");
    for (int i = 0; i < 16; i++)
      pop_expect(4'h3, lane_pay(64'h100 + 64'(i), 2), "R5 drain order");
    pop_expect(4'hF, 64'hB, "R6 error mask");
    expect_empty("R6 single error entry");
    offer(4'b0100, 64'h7700, 4'b0100, 1'b0, "R6 admission resumes");
    pop_expect(4'h3, lane_pay(64'h7700, 2), "R6 resumed entry");
  endtask

  task automatic t_overrun_full_dtm;
    for (int i = 0; i < 16; i++)
      offer(4'b0001, 64'h200 + 64'(i), 4'b0001, 1'b0, "R1 fill watch");
    offer(4'b1000, 64'hA000, 4'b1000, 1'b1, "R7 data hits full");
    for (int i = 0; i < 16; i++)
      pop_expect(4'h1, lane_pay(64'h200 + 64'(i), 0), "R5 drain watch");
    pop_expect(4'hF, 64'h8, "R6 error mask data only");
    expect_empty("R6 empty after error");
  endtask

  initial begin
    t_reset();
    t_singles();
    t_priority();
    t_overrun();
    t_overrun_full_dtm();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule